// File: doc/BRIEF.md
# UART Receive Byte Buffer

This block sits between the receive deserialiser of a 16550-style UART and the CPU register interface. Each byte the deserialiser finishes is offered on a one-cycle strobe. The buffer stores it, and the CPU drains it through a read strobe. The buffer has two modes. In buffered mode it holds up to sixteen bytes. It raises its receive request once the fill level reaches a programmable threshold. It also raises a separate idle-timeout request when bytes sit unread for four character times. In single-byte mode it behaves like a lone holding register.

The FIFO-control write port sets the mode, the threshold and a flush. The current line format (data bits, stop bits, parity) sets the length of a character in bit periods. A bit-period tick from the baud generator paces the idle timer. When a FIFO-control write lands in the same cycle as a byte strobe or a read strobe, the write takes precedence and that strobe is ignored. The interrupt prioritisation that combines these requests with other sources lies outside this block.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous reset, the block is in single-byte mode and rd_data, data_ready, overrun, rx_irq and timeout_irq are all zero.
- R2: In single-byte mode, a byte strobe sets data_ready and rx_irq. A read strobe presents the held byte on rd_data from the next cycle and clears data_ready and rx_irq.
- R3: In single-byte mode, a byte that arrives while data_ready is set (with no read in the same cycle) replaces the held byte and sets overrun. Overrun stays set until status_ack.
- R4: fcr_data[7:6] selects the threshold: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. In buffered mode, rx_irq is high exactly while the stored count is at or above the threshold.
- R5: In buffered mode, data_ready rises when the count reaches the threshold or the idle timer expires. It stays set until the buffer becomes empty.
- R6: Bytes leave in arrival order, and each read shows its byte on rd_data in the cycle after the read strobe.
- R7: The buffer holds 16 bytes. A byte that arrives while it is full is dropped, and overrun is set.
- R8: A character spans 1 start bit, 5 plus lcr_fmt[1:0] data bits, 1 stop bit, 1 more stop bit if lcr_fmt[2] is set, and 1 parity bit if lcr_fmt[3] is set. If the buffer is non-empty and sees no byte and no read for 4 characters of bit_tick pulses, timeout_irq and data_ready go high.
- R9: A read clears timeout_irq. If bytes remain, the idle count restarts from zero at that read.
- R10: A FIFO-control write with bit 0 set and bit 1 set empties the buffer and clears data_ready, rx_irq and timeout_irq.
- R11: A FIFO-control write whose bit 0 differs from the current mode switches mode (1 means buffered), discards all stored bytes and clears data_ready, rx_irq and timeout_irq.
- R12: A read strobe while the buffer is empty leaves rd_data and the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| rd_strobe | input | 1 | CPU read of the receive data register |
| status_ack | input | 1 | CPU read of line status; clears overrun |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_data | input | 8 | FIFO-control value: bit 0 mode, bit 1 flush, bits 7:6 threshold |
| lcr_fmt | input | 4 | Line format: bits 1:0 data length, bit 2 extra stop, bit 3 parity |
| bit_tick | input | 1 | One pulse per bit period |
| rd_data | output | 8 | Byte returned by the last accepted read |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | Sticky overrun status |
| rx_irq | output | 1 | Receive-data interrupt request |
| timeout_irq | output | 1 | Idle-timeout interrupt request |

## Verification
A wrong fill count shows up at rx_irq on the first write that crosses the threshold. It also shows up as a data_ready that drops one read too early or too late while draining. A pointer fault shows at rd_data on the first read after it occurs, as a byte out of order or a dropped byte that comes back. A wrong character length or a timer that fails to restart shifts the rise of timeout_irq by at least one tick. So the bench checks that edge in the exact cycle for every line format, and one cycle before it.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_e;

  function automatic int unsigned trig_depth(trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; holds its value when no read is accepted
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // read and write never target the same slot (empty/full guards)
  p_no_rw_collide_r6: assert property (@(posedge clk) disable iff (rst)
    !(we && re && (waddr == raddr)));

endmodule

// File: rtl/rxb_frame_len.sv
module rxb_frame_len #(
  parameter int TO_CHARS = 4,
  parameter int LW       = 8
) (
  input  logic [3:0]    lcr_fmt,
  output logic [LW-1:0] limit
);

  logic [3:0] bits;

  always_comb begin
    // start + 5..8 data + first stop + optional stop + optional parity
    bits  = 4'd7 + {2'b00, lcr_fmt[1:0]} + {3'b000, lcr_fmt[2]} + {3'b000, lcr_fmt[3]};
    limit = LW'(TO_CHARS) * LW'(bits);
  end

endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [LW-1:0] limit,
  output logic          fire
);

  logic [LW-1:0] cnt_q;

  assign fire = run && !restart && tick && (cnt_q >= limit - LW'(1));

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else if (tick)           cnt_q <= fire ? '0 : cnt_q + LW'(1);
  end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxb_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  parameter int LW       = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rd_strobe,
  input  logic          status_ack,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_data,
  input  logic [3:0]    lcr_fmt,
  input  logic          bit_tick,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          overrun,
  output logic          rx_irq,
  output logic          timeout_irq
);

  logic          fifo_en_q, dr_q, rxirq_q, pend_q, ovr_q, src_fifo_q;
  trig_e         trig_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [DW-1:0] hold_q, out_q;

  logic          unused_fcr;
  assign unused_fcr = ^fcr_data[5:2];

  // ---------------- decode of strobes ----------------
  logic mode_flip, flush_rx, acc_wr, drop_wr, acc_rd, any_rd;
  logic nf_wr, nf_rd;
  trig_e trig_n;
  logic [CW-1:0] thr, count_n;

  always_comb begin
    mode_flip = fcr_wr && (fcr_data[0] != fifo_en_q);
    flush_rx  = fcr_wr && (mode_flip || (fcr_data[0] && fcr_data[1]));
    acc_wr    = fifo_en_q && rx_valid && !fcr_wr && (count_q != CW'(DEPTH));
    drop_wr   = fifo_en_q && rx_valid && !fcr_wr && (count_q == CW'(DEPTH));
    any_rd    = fifo_en_q && rd_strobe && !fcr_wr;
    acc_rd    = any_rd && (count_q != '0);
    nf_wr     = !fifo_en_q && rx_valid && !fcr_wr;
    nf_rd     = !fifo_en_q && rd_strobe && !fcr_wr;
    trig_n    = fcr_wr ? trig_e'(fcr_data[7:6]) : trig_q;
    thr       = CW'(trig_depth(trig_n));
    if (flush_rx) count_n = '0;
    else          count_n = count_q + CW'(acc_wr) - CW'(acc_rd);
  end

  // ---------------- storage ----------------
  logic [DW-1:0] mem_rdata;

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (acc_wr),
    .waddr (wptr_q),
    .wdata (rx_data),
    .re    (acc_rd),
    .raddr (rptr_q),
    .rdata (mem_rdata)
  );

  // ---------------- idle timeout ----------------
  logic [LW-1:0] limit;
  logic          tmr_run, tmr_restart, fire;

  rxb_frame_len #(.TO_CHARS(TO_CHARS), .LW(LW)) u_frame_len (
    .lcr_fmt (lcr_fmt),
    .limit   (limit)
  );

  assign tmr_run     = fifo_en_q && (count_q != '0) && !pend_q;
  assign tmr_restart = acc_wr || any_rd || fcr_wr;

  rxb_idle_timer #(.LW(LW)) u_idle_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .restart (tmr_restart),
    .tick    (bit_tick),
    .limit   (limit),
    .fire    (fire)
  );

  // ---------------- next-state of flags ----------------
  logic dr_n, rxirq_n, pend_n, ovr_n;

  always_comb begin
    dr_n = dr_q;
    if (mode_flip) begin
      dr_n = 1'b0;
    end else if (fifo_en_q) begin
      if (flush_rx || count_n == '0)  dr_n = 1'b0;
      else if (count_n >= thr || fire) dr_n = 1'b1;
    end else begin
      if (nf_wr)      dr_n = 1'b1;
      else if (nf_rd) dr_n = 1'b0;
    end

    if (mode_flip)      rxirq_n = 1'b0;
    else if (fifo_en_q) rxirq_n = (count_n >= thr);
    else                rxirq_n = dr_n;

    pend_n = pend_q;
    if (flush_rx || any_rd) pend_n = 1'b0;
    else if (fire)          pend_n = 1'b1;

    ovr_n = ovr_q;
    if (status_ack) ovr_n = 1'b0;
    if (drop_wr || (nf_wr && dr_q && !rd_strobe)) ovr_n = 1'b1;
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q  <= 1'b0;
      trig_q     <= TRIG_1;
      count_q    <= '0;
      wptr_q     <= '0;
      rptr_q     <= '0;
      dr_q       <= 1'b0;
      rxirq_q    <= 1'b0;
      pend_q     <= 1'b0;
      ovr_q      <= 1'b0;
      hold_q     <= '0;
      out_q      <= '0;
      src_fifo_q <= 1'b0;
    end else begin
      if (fcr_wr) fifo_en_q <= fcr_data[0];
      trig_q  <= trig_n;
      count_q <= count_n;
      if (flush_rx) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (acc_wr) wptr_q <= wptr_q + AW'(1);
        if (acc_rd) rptr_q <= rptr_q + AW'(1);
      end
      dr_q    <= dr_n;
      rxirq_q <= rxirq_n;
      pend_q  <= pend_n;
      ovr_q   <= ovr_n;
      if (nf_wr) hold_q <= rx_data;
      if (nf_rd) begin
        out_q      <= hold_q;
        src_fifo_q <= 1'b0;
      end else if (acc_rd) begin
        src_fifo_q <= 1'b1;
      end
    end
  end

  assign rd_data     = src_fifo_q ? mem_rdata : out_q;
  assign data_ready  = dr_q;
  assign overrun     = ovr_q;
  assign rx_irq      = rxirq_q;
  assign timeout_irq = pend_q;

  // ---------------- assertions ----------------
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  p_timeout_mode_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> fifo_en_q);

  p_read_clears_to_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !fcr_wr) |=> !timeout_irq);

  p_ovr_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_valid));

  p_dr_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(data_ready) |-> $past(rd_strobe || fcr_wr));

endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rd_strobe = 1'b0;
  logic       status_ack = 1'b0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_data = '0;
  logic [3:0] lcr_fmt = '0;
  logic       bit_tick = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, rx_irq, timeout_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (
    .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_data (rx_data),
    .rd_strobe (rd_strobe), .status_ack (status_ack), .fcr_wr (fcr_wr),
    .fcr_data (fcr_data), .lcr_fmt (lcr_fmt), .bit_tick (bit_tick),
    .rd_data (rd_data), .data_ready (data_ready), .overrun (overrun),
    .rx_irq (rx_irq), .timeout_irq (timeout_irq)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // every task is entered at a negedge and consumes one clock edge
  task automatic put(logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic fcr(logic [7:0] v);
    fcr_wr = 1'b1; fcr_data = v;
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic ack();
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 timeout_irq", timeout_irq, 0);

    // R2 single-byte mode
    put(8'hA5);
    chk("R2 data_ready", data_ready, 1);
    chk("R2 rx_irq", rx_irq, 1);
    rd();
    chk("R2 rd_data", rd_data, 8'hA5);
    chk("R2 data_ready clr", data_ready, 0);
    chk("R2 rx_irq clr", rx_irq, 0);

    // R3 single-byte overrun replaces held byte
    put(8'h11);
    chk("R3 no overrun yet", overrun, 0);
    put(8'h22);
    chk("R3 overrun", overrun, 1);
    rd();
    chk("R3 replaced byte", rd_data, 8'h22);
    chk("R3 overrun sticky", overrun, 1);
    ack();
    chk("R3 overrun ack", overrun, 0);

    // R11 enter buffered mode
    fcr(8'h01);

    // R4/R5/R6/R7/R12 threshold sweep, fill to full and drain
    for (int lvl = 0; lvl < 4; lvl++) begin
      int t;
      logic [7:0] base;
      t = (lvl == 0) ? 1 : (lvl == 1) ? 4 : (lvl == 2) ? 8 : 14;
      base = 8'(lvl * 32 + 3);
      fcr(8'({lvl[1:0], 6'b000011}));
      for (int n = 1; n <= 16; n++) begin
        put(base + 8'(n));
        chk("R4 rx_irq on fill", rx_irq, (n >= t) ? 1 : 0);
        chk("R5 data_ready on fill", data_ready, (n >= t) ? 1 : 0);
      end
      chk("R7 no overrun at 16", overrun, 0);
      put(8'hEE);
      chk("R7 overrun when full", overrun, 1);
      ack();
      for (int n = 1; n <= 16; n++) begin
        rd();
        chk("R6 order", rd_data, base + 8'(n));
        chk("R5 data_ready drain", data_ready, (n < 16) ? 1 : 0);
        chk("R4 rx_irq drain", rx_irq, ((16 - n) >= t) ? 1 : 0);
      end
      rd();
      chk("R12 empty read keeps data", rd_data, base + 8'd16);
      chk("R7 dropped byte absent", data_ready, 0);
      last = base + 8'd16;
    end

    // R10 flush
    fcr(8'h03);
    put(8'h51); put(8'h52); put(8'h53);
    chk("R10 pre-flush ready", data_ready, 1);
    fcr(8'h03);
    chk("R10 flush data_ready", data_ready, 0);
    chk("R10 flush rx_irq", rx_irq, 0);
    rd();
    chk("R10 flush empties", rd_data, last);

    // R8 idle timeout for every line format
    for (int f = 0; f < 16; f++) begin
      int lim;
      logic [7:0] b;
      lim = 4 * (7 + (f & 3) + ((f >> 2) & 1) + ((f >> 3) & 1));
      b = 8'(f + 8'h60);
      lcr_fmt = 4'(f);
      fcr(8'hC3);
      bit_tick = 1'b1;
      put(b);
      repeat (lim - 1) @(negedge clk);
      chk("R8 timeout not early", timeout_irq, 0);
      chk("R8 ready not early", data_ready, 0);
      @(negedge clk);
      chk("R8 timeout fires", timeout_irq, 1);
      chk("R8 timeout sets ready", data_ready, 1);
      rd();
      bit_tick = 1'b0;
      chk("R9 read clears timeout", timeout_irq, 0);
      chk("R9 read data", rd_data, b);
      chk("R5 empty clears ready", data_ready, 0);
    end

    // R9 restart after partial read
    lcr_fmt = 4'd0;
    fcr(8'hC3);
    put(8'h71); put(8'h72);
    bit_tick = 1'b1;
    repeat (28) @(negedge clk);
    chk("R9 first timeout", timeout_irq, 1);
    rd();
    chk("R9 cleared by read", timeout_irq, 0);
    chk("R9 first byte", rd_data, 8'h71);
    repeat (27) @(negedge clk);
    chk("R9 restarted not early", timeout_irq, 0);
    @(negedge clk);
    chk("R9 restarted fires", timeout_irq, 1);
    bit_tick = 1'b0;
    rd();
    chk("R9 second byte", rd_data, 8'h72);

    // R11 mode switch discards content
    fcr(8'h03);
    put(8'h81); put(8'h82);
    chk("R11 pre-switch ready", data_ready, 1);
    fcr(8'h00);
    chk("R11 switch data_ready", data_ready, 0);
    chk("R11 switch rx_irq", rx_irq, 0);
    fcr(8'h01);
    rd();
    chk("R11 bytes discarded", rd_data, 8'h72);
    chk("R11 still empty", data_ready, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule